// File: doc/BRIEF.md
# Normalizing Barrel Shifter

This is the shift unit of a 16-bit fixed-point datapath. Each cycle it takes one 16-bit operand, an 8-bit signed amount and a 3-bit opcode. It performs one of these operations:

- a logical shift by the signed amount;
- an arithmetic shift by the signed amount;
- exponent derivation, which counts the redundant sign bits of the operand;
- normalization by that derived count;
- denormalization, which is an arithmetic right shift by a supplied exponent.

The result is a 32-bit word, registered one clock after the request. An opcode bit selects whether the operand is placed in the upper or the lower half of that word. This lets software build a 32-bit shift from two operations that are ORed together.

A block-exponent tracker keeps the smallest exponent derived over a series of values. Software then scales the whole series with one shared exponent. The tracker is a two-state machine:

- EMPTY: no value has arrived since reset or since the last clear.
- TRACK: at least one value has arrived.

The transitions are:

- EMPTY to TRACK on the first block-exponent request that is not cleared in the same cycle.
- TRACK to EMPTY on a clear.
- EMPTY stays EMPTY without such a request.
- TRACK stays TRACK without a clear.

Top module: `norm_shifter`

## Requirements
- R1: While reset is held, `result_o` reads 0, `exp_o` reads 0 and `blk_exp_o` reads 15.
- R2: Operand placement uses `hi_i`. When `hi_i` is 1, the operand sits in bits 31:16 and bits 15:0 are zero. When `hi_i` is 0, the operand sits in bits 15:0. For opcode 0 the upper half is then zero-filled. For opcodes 1, 3 and 4 it is filled with operand bit 15.
- R3: Opcode 0 is a logical shift of the placed word. A positive `amount_i` shifts left and a negative one shifts right, and both directions fill with zeros.
- R4: Opcode 1 is an arithmetic shift of the placed word. A positive amount shifts left with zero fill. A negative amount shifts right and fills with bit 31 of the placed word.
- R5: For opcodes 0 and 1, an amount of 32 or more in magnitude gives all zeros. The one exception is an arithmetic right shift, which gives 32 copies of bit 31 of the placed word.
- R6: Opcode 2 derives the exponent. This is the count of bits below bit 15 that equal bit 15 before the first bit that differs, so 0x0000 and 0xFFFF give 15. The count goes to `exp_o`, and `result_o` holds the count zero-extended.
- R7: Opcode 3 shifts the placed word left by the derived exponent of the operand and writes that exponent to `exp_o`.
- R8: Opcode 4 shifts the placed word arithmetically right. The amount is read as an unsigned count from 0 to 255, and a count of 32 or more gives all sign bits.
- R9: Opcode 5 updates `result_o` and `exp_o` the same way opcode 2 does. It also sets `blk_exp_o` to the smaller of its current value and the new exponent.
- R10: A high `blk_clr_i` sets `blk_exp_o` to 15 at the next edge. The clear wins over an opcode 5 in the same cycle; the clear does not block that request's updates to `result_o` and `exp_o`.
- R11: With `valid_i` low, or with opcode 6 or 7, `result_o`, `exp_o` and `blk_exp_o` keep their values.
- R12: Outputs change only at the first rising clock edge after the request and hold their previous values before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Request strobe |
| op_i | input | 3 | Opcode (0 lsh, 1 ash, 2 exp, 3 norm, 4 denorm, 5 block exp) |
| hi_i | input | 1 | Place operand in upper half |
| operand_i | input | 16 | Fixed-point operand |
| amount_i | input | 8 | Signed shift amount, or unsigned exponent for opcode 4 |
| blk_clr_i | input | 1 | Clear the block exponent |
| result_o | output | 32 | Registered 32-bit result |
| exp_o | output | 4 | Last derived exponent |
| blk_exp_o | output | 4 | Running minimum block exponent |

## Verification
The bench targets amounts at and beyond the 32-bit edge, including -128. A shifter that wrapped the count modulo 32 would return a shifted copy there instead of a flood of zeros or sign bits.

Exponents of 0x0000, 0xFFFF, 0x4000, 0x0001 and 0xC000 probe off-by-one errors in the sign-run count. Normalizing such values exposes a shift that leaves bits 31 and 30 equal.

Block sequences test several things:
- a clear in the same cycle as a block request, which a wrong priority would let through;
- lower-half placement, where a wrong sign extension corrupts the upper half;
- requests that are invalid or carry unused opcodes, which must leave every output unchanged.

// File: rtl/ns_pkg.sv
package ns_pkg;

    typedef enum logic [2:0] {
        OP_LSH    = 3'd0,
        OP_ASH    = 3'd1,
        OP_EXP    = 3'd2,
        OP_NORM   = 3'd3,
        OP_DENORM = 3'd4,
        OP_BLKEXP = 3'd5,
        OP_RSV6   = 3'd6,
        OP_RSV7   = 3'd7
    } ns_op_e;

    typedef enum logic {
        BLK_EMPTY = 1'b0,
        BLK_TRACK = 1'b1
    } blk_state_e;

endpackage

// File: rtl/ns_expdet.sv
module ns_expdet #(
    parameter int DW = 16,
    parameter int EW = $clog2(DW)
) (
    input  logic [DW-1:0] d,
    output logic [EW-1:0] e
);

    // Count the sign-bit copies directly below the sign bit.
    always_comb begin
        logic run;
        e   = '0;
        run = 1'b1;
        for (int i = DW - 2; i >= 0; i--) begin
            if (run && (d[i] == d[DW-1])) begin
                e = e + EW'(1);
            end else begin
                run = 1'b0;
            end
        end
    end

endmodule

// File: rtl/ns_barrel.sv
module ns_barrel #(
    parameter int RW = 32,
    parameter int MW = 8,
    parameter int CW = $clog2(RW)
) (
    input  logic [RW-1:0] d,
    input  logic          left,
    input  logic          fill,
    input  logic [MW-1:0] mag,
    output logic [RW-1:0] q
);

    logic [RW-1:0] st [0:CW];
    logic          big;

    assign st[0] = d;
    assign big   = (mag >= MW'(RW));

    // One stage per bit of the count; each stage moves by a power of two.
    for (genvar k = 0; k < CW; k++) begin : g_stage
        localparam int S = 1 << k;
        logic [RW-1:0] sl;
        logic [RW-1:0] sr;
        assign sl = {st[k][RW-1-S:0], {S{1'b0}}};
        assign sr = {{S{fill}}, st[k][RW-1:S]};
        assign st[k+1] = mag[k] ? (left ? sl : sr) : st[k];
    end

    assign q = big ? (left ? '0 : {RW{fill}}) : st[CW];

endmodule

// File: rtl/ns_blkexp.sv
module ns_blkexp
    import ns_pkg::*;
#(
    parameter int DW = 16,
    parameter int EW = $clog2(DW)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          upd,
    input  logic [EW-1:0] exp_in,
    output logic [EW-1:0] blk_exp
);

    localparam logic [EW-1:0] EXP_MAX = EW'(DW - 1);

    blk_state_e state, nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= BLK_EMPTY;
        end else begin
            state <= nxt;
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            BLK_EMPTY: nxt = (upd && !clr) ? BLK_TRACK : BLK_EMPTY;
            BLK_TRACK: nxt = clr ? BLK_EMPTY : BLK_TRACK;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            blk_exp <= EXP_MAX;
        end else if (clr) begin
            blk_exp <= EXP_MAX;
        end else if (upd) begin
            unique case (state)
                BLK_EMPTY: blk_exp <= exp_in;
                BLK_TRACK: blk_exp <= (exp_in < blk_exp) ? exp_in : blk_exp;
            endcase
        end
    end

endmodule

// File: rtl/norm_shifter.sv
module norm_shifter
    import ns_pkg::*;
#(
    parameter int DW = 16,
    parameter int AW = 8,
    parameter int RW = 2 * DW,
    parameter int EW = $clog2(DW)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          valid_i,
    input  logic [2:0]    op_i,
    input  logic          hi_i,
    input  logic [DW-1:0] operand_i,
    input  logic [AW-1:0] amount_i,
    input  logic          blk_clr_i,
    output logic [RW-1:0] result_o,
    output logic [EW-1:0] exp_o,
    output logic [EW-1:0] blk_exp_o
);

    ns_op_e        op;
    logic [EW-1:0] dexp;
    logic [RW-1:0] placed;
    logic          ext;
    logic [AW-1:0] amt_mag;
    logic [AW-1:0] sh_mag;
    logic          sh_left;
    logic          sh_fill;
    logic [RW-1:0] sh_q;
    logic [RW-1:0] res_n;
    logic          known;
    logic          exp_wr;

    assign op = ns_op_e'(op_i);

    ns_expdet #(.DW(DW), .EW(EW)) u_expdet (
        .d (operand_i),
        .e (dexp)
    );

    assign ext     = (op == OP_ASH || op == OP_NORM || op == OP_DENORM) ? operand_i[DW-1] : 1'b0;
    assign placed  = hi_i ? {operand_i, {DW{1'b0}}} : {{DW{ext}}, operand_i};
    assign amt_mag = amount_i[AW-1] ? AW'(-amount_i) : amount_i;

    always_comb begin
        sh_left = 1'b1;
        sh_fill = 1'b0;
        sh_mag  = '0;
        unique case (op)
            OP_LSH: begin
                sh_left = !amount_i[AW-1];
                sh_mag  = amt_mag;
            end
            OP_ASH: begin
                sh_left = !amount_i[AW-1];
                sh_fill = placed[RW-1];
                sh_mag  = amt_mag;
            end
            OP_NORM: begin
                sh_mag = AW'(dexp);
            end
            OP_DENORM: begin
                sh_left = 1'b0;
                sh_fill = placed[RW-1];
                sh_mag  = amount_i;
            end
            default: begin
                sh_mag = '0;
            end
        endcase
    end

    ns_barrel #(.RW(RW), .MW(AW)) u_barrel (
        .d    (placed),
        .left (sh_left),
        .fill (sh_fill),
        .mag  (sh_mag),
        .q    (sh_q)
    );

    always_comb begin
        known  = 1'b1;
        exp_wr = 1'b0;
        res_n  = sh_q;
        unique case (op)
            OP_LSH, OP_ASH, OP_DENORM: res_n = sh_q;
            OP_NORM: exp_wr = 1'b1;
            OP_EXP, OP_BLKEXP: begin
                res_n  = RW'(dexp);
                exp_wr = 1'b1;
            end
            OP_RSV6, OP_RSV7: known = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result_o <= '0;
            exp_o    <= '0;
        end else if (valid_i && known) begin
            result_o <= res_n;
            if (exp_wr) begin
                exp_o <= dexp;
            end
        end
    end

    ns_blkexp #(.DW(DW), .EW(EW)) u_blk (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (blk_clr_i),
        .upd     (valid_i && op == OP_BLKEXP),
        .exp_in  (dexp),
        .blk_exp (blk_exp_o)
    );

endmodule

// File: rtl/norm_shifter_chk.sv
module norm_shifter_chk #(
    parameter int DW = 16,
    parameter int AW = 8,
    parameter int RW = 2 * DW,
    parameter int EW = $clog2(DW)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          valid_i,
    input logic [2:0]    op_i,
    input logic          hi_i,
    input logic [DW-1:0] operand_i,
    input logic [AW-1:0] amount_i,
    input logic          blk_clr_i,
    input logic [RW-1:0] result_o,
    input logic [EW-1:0] exp_o,
    input logic [EW-1:0] blk_exp_o
);

    // R9
    blk_no_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !blk_clr_i |=> blk_exp_o <= $past(blk_exp_o));

    // R10
    blk_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        blk_clr_i |=> blk_exp_o == EW'(DW - 1));

    // R11
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid_i || op_i > 3'd5) |=> ($stable(result_o) && $stable(exp_o)));

    // R6
    exp_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && op_i == 3'd2) |=> result_o[RW-1:EW] == '0);

    // R7
    norm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && op_i == 3'd3 && hi_i && operand_i != '0 && operand_i != '1)
        |=> result_o[RW-1] != result_o[RW-2]);

    // R5
    lsh_big_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && op_i == 3'd0 && (($signed(amount_i) >= 32) || ($signed(amount_i) <= -32)))
        |=> result_o == '0);

endmodule

bind norm_shifter norm_shifter_chk u_chk (.*);

// File: tb/norm_shifter_tb.sv
module norm_shifter_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid_i = 1'b0;
    logic [2:0]  op_i = '0;
    logic        hi_i = 1'b0;
    logic [15:0] operand_i = '0;
    logic [7:0]  amount_i = '0;
    logic        blk_clr_i = 1'b0;
    logic [31:0] result_o;
    logic [3:0]  exp_o;
    logic [3:0]  blk_exp_o;

    int checks = 0;
    int fails = 0;
    logic [31:0] m_res = '0;
    logic [3:0]  m_exp = '0;
    logic [3:0]  m_blk = 4'd15;

    always #(CLK_PERIOD / 2) clk = ~clk;

    norm_shifter u_dut (
        .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .op_i(op_i), .hi_i(hi_i),
        .operand_i(operand_i), .amount_i(amount_i), .blk_clr_i(blk_clr_i),
        .result_o(result_o), .exp_o(exp_o), .blk_exp_o(blk_exp_o)
    );

    function automatic logic [3:0] f_exp(logic [15:0] v);
        int n = 0;
        for (int i = 14; i >= 0; i--) begin
            if (v[i] != v[15]) break;
            n++;
        end
        return 4'(n);
    endfunction

    function automatic logic [31:0] f_place(logic [2:0] op, logic hi, logic [15:0] v);
        logic sx = (op == 3'd1 || op == 3'd3 || op == 3'd4) ? v[15] : 1'b0;
        if (hi) return {v, 16'h0000};
        return {{16{sx}}, v};
    endfunction

    function automatic logic [31:0] f_left(logic [31:0] w, int n);
        if (n >= 32) return '0;
        return w << n;
    endfunction

    function automatic logic [31:0] f_right(logic [31:0] w, int n, logic arith);
        if (n >= 32) return arith ? {32{w[31]}} : '0;
        if (arith) return $unsigned($signed(w) >>> n);
        return w >> n;
    endfunction

    task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Drive one request at a falling edge, check R12 hold, then check after the edge.
    task automatic apply(logic v, logic [2:0] op, logic hi, logic [15:0] d,
                         logic [7:0] amt, logic clr, string tg);
        int sa;
        string t;
        logic [31:0] w;
        logic [3:0] e;
        valid_i = v; op_i = op; hi_i = hi; operand_i = d; amount_i = amt; blk_clr_i = clr;
        sa = $signed(amt);
        w = f_place(op, hi, d);
        e = f_exp(d);
        t = tg;
        #1;
        check("R12", "result before edge", result_o, m_res);
        if (v && op <= 3'd5) begin
            case (op)
                3'd0: m_res = (sa >= 0) ? f_left(w, sa) : f_right(w, -sa, 1'b0);
                3'd1: m_res = (sa >= 0) ? f_left(w, sa) : f_right(w, -sa, 1'b1);
                3'd3: m_res = f_left(w, int'(e));
                3'd4: m_res = f_right(w, int'(amt), 1'b1);
                default: m_res = {28'h0, e};
            endcase
            if (op == 3'd2 || op == 3'd3 || op == 3'd5) m_exp = e;
        end
        if (clr) m_blk = 4'd15;
        else if (v && op == 3'd5 && e < m_blk) m_blk = e;
        if (t == "") begin
            if (!v || op > 3'd5) t = "R11";
            else if (op <= 3'd1 && (sa >= 32 || sa <= -32)) t = "R5";
            else begin
                case (op)
                    3'd0: t = "R3";
                    3'd1: t = "R4";
                    3'd2: t = "R6";
                    3'd3: t = "R7";
                    3'd4: t = "R8";
                    default: t = "R9";
                endcase
            end
        end
        @(negedge clk);
        check(t, "result", result_o, m_res);
        check(t, "exp", 32'(exp_o), 32'(m_exp));
        check(clr ? "R10" : t, "blk_exp", 32'(blk_exp_o), 32'(m_blk));
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", checks + 1 - fails, checks + 1);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        // R1 reset values
        check("R1", "result", result_o, 32'h0);
        check("R1", "exp", 32'(exp_o), 32'h0);
        check("R1", "blk_exp", 32'(blk_exp_o), 32'd15);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 placement with zero shift
        apply(1, 3'd0, 1, 16'h8001, 8'd0, 0, "R2");
        apply(1, 3'd0, 0, 16'h8001, 8'd0, 0, "R2");
        apply(1, 3'd1, 0, 16'h8001, 8'd0, 0, "R2");
        // R3 / R4 shifts
        apply(1, 3'd0, 0, 16'h8001, 8'd4, 0, "R3");
        apply(1, 3'd0, 1, 16'h8001, 8'hFC, 0, "R3");
        apply(1, 3'd1, 1, 16'h8000, 8'hF8, 0, "R4");
        // R5 large amounts
        apply(1, 3'd1, 0, 16'h8000, 8'hD8, 0, "R5");
        apply(1, 3'd0, 1, 16'hFFFF, 8'd32, 0, "R5");
        apply(1, 3'd0, 1, 16'hFFFF, 8'h80, 0, "R5");
        apply(1, 3'd1, 1, 16'h7FFF, 8'h80, 0, "R5");
        // R6 exponents
        apply(1, 3'd2, 0, 16'h0000, 8'd0, 0, "R6");
        apply(1, 3'd2, 0, 16'hFFFF, 8'd0, 0, "R6");
        apply(1, 3'd2, 0, 16'h4000, 8'd0, 0, "R6");
        apply(1, 3'd2, 0, 16'h0001, 8'd0, 0, "R6");
        apply(1, 3'd2, 0, 16'hC000, 8'd0, 0, "R6");
        // R7 / R8
        apply(1, 3'd3, 1, 16'h0100, 8'd0, 0, "R7");
        apply(1, 3'd3, 0, 16'hFF80, 8'd0, 0, "R7");
        apply(1, 3'd4, 1, 16'h9000, 8'd3, 0, "R8");
        apply(1, 3'd4, 0, 16'h9000, 8'd200, 0, "R8");
        // R9 / R10 block exponent
        apply(1, 3'd5, 0, 16'h0010, 8'd0, 0, "R9");
        apply(1, 3'd5, 0, 16'h0800, 8'd0, 0, "R9");
        apply(1, 3'd5, 0, 16'h0001, 8'd0, 0, "R9");
        apply(1, 3'd5, 0, 16'h0001, 8'd0, 1, "R10");
        apply(1, 3'd5, 0, 16'h0100, 8'd0, 0, "R9");
        // R11 ignored requests
        apply(0, 3'd5, 0, 16'h4000, 8'd0, 0, "R11");
        apply(1, 3'd6, 1, 16'h1234, 8'd3, 0, "R11");
        apply(1, 3'd7, 0, 16'h0000, 8'd1, 0, "R11");

        for (int n = 0; n < 400; n++) begin
            logic [7:0] a;
            a = 8'($urandom);
            if ($urandom_range(3) == 0) a = 8'($signed(6'($urandom)));
            apply($urandom_range(9) != 0, 3'($urandom), 1'($urandom),
                  16'($urandom) >> $urandom_range(15), a, $urandom_range(19) == 0, "");
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule